// File: doc/BRIEF.md
# Interval Timer with Snapshot Latch

This block is a 32-bit down-counting interval timer controlled over a small word-addressed register bus with 32-bit data. Software programs a reload period as two 16-bit halves, chooses one-shot or continuous operation, and starts or stops the count with self-clearing strobe bits. When the count is exhausted, a sticky timeout flag is raised, and an interrupt line follows it when enabled.

Because the live count is wider than a single 16-bit field, it is never read directly. A bus write to either snapshot location copies the whole live count into a latch in one cycle, so both halves can then be read without one half moving between the two reads. The count runs downward, so the bitwise inverse of a snapshot is an elapsed-cycle value that grows; with an all-ones period and continuous mode the timer free-runs as a 32-bit time base.

Reads are combinational from registered state: the read data for the address presented in a cycle reflects the state left by the previous clock edge. Writes take effect at the clock edge of the cycle in which they are presented.

Top module: `tmr_interval_top`

## Requirements
- R1: After reset, status reads 0, control reads 0, both period halves read 0xFFFF, both snapshot halves read 0 and irq is low.
- R2: Word addresses are: 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 snapshot bits 15:0, 5 snapshot bits 31:16; addresses 6 and 7 read 0. Status bit 0 is timeout and bit 1 is running; control bit 0 is interrupt enable, bit 1 continuous mode, bit 2 start strobe, bit 3 stop strobe. Unused bits read 0; period and snapshot halves occupy data bits 15:0.
- R3: While running with a nonzero count, the count falls by one per clock; at an edge where it is running with count zero, timeout is set and, in continuous mode, the count reloads from the period.
- R4: In one-shot mode (control bit 1 clear), the edge that finds the count at zero sets timeout, clears running and leaves the count at zero.
- R5: A start strobe sets running and, if the count is zero, reloads it from the period; a stop strobe clears running and freezes the count; with both strobes in one write, stop wins. Strobe bits always read back as 0.
- R6: A write to either period half updates only that half and reloads the live count with the new full 32-bit period at the same edge; the running state is unchanged.
- R7: A write to address 4 or 5 copies the live count present before that edge into the snapshot latch; the snapshot then holds its value while the count keeps moving.
- R8: Any write to status clears timeout; a timeout occurring at the same edge wins and leaves timeout set.
- R9: irq is high exactly when timeout and interrupt enable are both set.
- R10: With both period halves at 0xFFFF and continuous mode, the inverse of two snapshots taken K cycles apart differs by exactly K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | Access is a write when high, a read when low |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, zero when not selected |
| irq | output | 1 | Interrupt request, timeout gated by enable |

## Verification
The hardest situations to reach are edge collisions: a status clear landing on the very edge that a new timeout occurs, a period write landing while the counter is mid-count, and a one-shot restart issued when the count already sits at zero. The stimulus reaches them by spacing every bus access exactly one clock apart and inserting counted idle cycles, so the bench knows, from the programmed period alone, which edge the counter hits zero and can aim a write at it. Snapshots taken at known slots then expose the exact count value, showing reloads, freezes and free-run elapsed time through the ordinary register interface.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // Word address width of the register window
    localparam int ADDR_W = 3;

    // Register word addresses (software-visible map)
    localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PER_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SNP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_SNP_HI = 3'd5;

    // Status bit positions
    localparam int ST_TO  = 0;
    localparam int ST_RUN = 1;

    // Control bit positions
    localparam int CTL_IEN   = 0;
    localparam int CTL_CONT  = 1;
    localparam int CTL_START = 2;
    localparam int CTL_STOP  = 3;

    // Decoded write strobes, at most one active per cycle
    typedef struct packed {
        logic stat;
        logic ctrl;
        logic per_lo;
        logic per_hi;
        logic snap;
    } tmr_wstb_t;

endpackage

// File: rtl/tmr_bus_decode.sv
`timescale 1ns/1ps
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              st_timeout,
    input  logic              st_running,
    input  logic              cf_ien,
    input  logic              cf_cont,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  snap,
    output tmr_wstb_t         wstb,
    output logic [DATA_W-1:0] rdata
);

    localparam int HALF_W = CNT_W / 2;

    logic wen;
    assign wen = sel && wr;

    // Write strobes
    always_comb begin
        wstb        = '0;
        wstb.stat   = wen && (addr == ADR_STAT);
        wstb.ctrl   = wen && (addr == ADR_CTRL);
        wstb.per_lo = wen && (addr == ADR_PER_LO);
        wstb.per_hi = wen && (addr == ADR_PER_HI);
        wstb.snap   = wen && ((addr == ADR_SNP_LO) || (addr == ADR_SNP_HI));
    end

    // Read multiplexer: unused bits and addresses return zero
    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (addr)
                ADR_STAT: begin
                    rdata[ST_TO]  = st_timeout;
                    rdata[ST_RUN] = st_running;
                end
                ADR_CTRL: begin
                    rdata[CTL_IEN]  = cf_ien;
                    rdata[CTL_CONT] = cf_cont;
                end
                ADR_PER_LO: rdata[HALF_W-1:0] = period[HALF_W-1:0];
                ADR_PER_HI: rdata[HALF_W-1:0] = period[CNT_W-1:HALF_W];
                ADR_SNP_LO: rdata[HALF_W-1:0] = snap[HALF_W-1:0];
                ADR_SNP_HI: rdata[HALF_W-1:0] = snap[CNT_W-1:HALF_W];
                default:    rdata = '0;
            endcase
        end
    end

    // R2: the address decode never fires two register writes at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wstb.stat, wstb.ctrl, wstb.per_lo, wstb.per_hi, wstb.snap}))
        else $error("a_r2_one_strobe");

endmodule

// File: rtl/tmr_cfg.sv
`timescale 1ns/1ps
module tmr_cfg
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_per_lo,
    input  logic                wr_per_hi,
    input  logic [CNT_W/2-1:0]  wdata,
    output logic                ien,
    output logic                cont,
    output logic                start_pls,
    output logic                stop_pls,
    output logic [CNT_W-1:0]    period,
    output logic [CNT_W-1:0]    per_next,
    output logic                per_load
);

    localparam int HALF_W = CNT_W / 2;
    localparam int N_HALF = 2;

    typedef struct packed {
        logic             ien;
        logic             cont;
        logic [CNT_W-1:0] per;
    } cfg_s;

    cfg_s q, d;
    logic [N_HALF-1:0] half_wr;

    assign half_wr = {wr_per_hi, wr_per_lo};

    // Next-state: each period half loads independently
    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.ien  = wdata[CTL_IEN];
            d.cont = wdata[CTL_CONT];
        end
        for (int h = 0; h < N_HALF; h++) begin
            if (half_wr[h]) begin
                d.per[h*HALF_W +: HALF_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ien  <= 1'b0;
            q.cont <= 1'b0;
            q.per  <= '1;
        end else begin
            q <= d;
        end
    end

    assign ien       = q.ien;
    assign cont      = q.cont;
    assign period    = q.per;
    assign per_next  = d.per;
    assign per_load  = |half_wr;
    assign start_pls = wr_ctrl && wdata[CTL_START];
    assign stop_pls  = wr_ctrl && wdata[CTL_STOP];

    // R6: a low-half write leaves the high half untouched, and vice versa
    a_r6_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per_lo && !wr_per_hi) |=> $stable(q.per[CNT_W-1:HALF_W]))
        else $error("a_r6_hi_kept");
    a_r6_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per_hi && !wr_per_lo) |=> $stable(q.per[HALF_W-1:0]))
        else $error("a_r6_lo_kept");

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pls,
    input  logic             stop_pls,
    input  logic             cont,
    input  logic             per_load,
    input  logic [CNT_W-1:0] per_next,
    input  logic             clr_to,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             timeout
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             to;
    } core_s;

    core_s q, d;
    logic  at_zero;
    logic  expire;

    assign at_zero = (q.count == '0);
    assign expire  = q.run && at_zero;

    always_comb begin
        d = q;
        // counting and expiry
        if (q.run) begin
            if (at_zero) begin
                if (cont) begin
                    d.count = per_next;
                end else begin
                    d.run = 1'b0;
                end
            end else begin
                d.count = q.count - CNT_W'(1);
            end
        end
        // sticky timeout: a new expiry outranks a software clear
        d.to = (q.to && !clr_to) || expire;
        // strobes: stop outranks start
        if (start_pls && !stop_pls) begin
            d.run = 1'b1;
            if (at_zero) begin
                d.count = per_next;
            end
        end
        if (stop_pls) begin
            d.run = 1'b0;
        end
        // a period write reloads the full new period
        if (per_load) begin
            d.count = per_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count   = q.count;
    assign running = q.run;
    assign timeout = q.to;

    // R3: one step down per clock while running
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !at_zero && !per_load) |=> (q.count == $past(q.count) - CNT_W'(1)))
        else $error("a_r3_step_down");
    // R3: continuous mode reloads at zero
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && at_zero && cont) |=> (q.count == $past(per_next)))
        else $error("a_r3_reload");
    // R4: one-shot halts at zero
    a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && at_zero && !cont && !start_pls && !per_load) |=> (!q.run && q.count == '0))
        else $error("a_r4_oneshot_halt");
    // R5: stop always wins
    a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pls |=> !q.run)
        else $error("a_r5_stop_wins");
    // R5: a lone start always runs
    a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pls && !stop_pls) |=> q.run)
        else $error("a_r5_start_runs");
    // R6: period write reloads the count
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        per_load |=> (q.count == $past(per_next)))
        else $error("a_r6_reload");
    // R8: expiry sets timeout even during a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> q.to)
        else $error("a_r8_set_wins");
    // R8: a clear without expiry drops timeout
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_to && !expire) |=> !q.to)
        else $error("a_r8_clear");

endmodule

// File: rtl/tmr_snap.sv
`timescale 1ns/1ps
module tmr_snap #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] snap
);

    logic [CNT_W-1:0] snap_q, snap_d;

    always_comb begin
        snap_d = snap_q;
        if (take) begin
            snap_d = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap = snap_q;

    // R7: capture the pre-edge live count, then hold
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (snap_q == $past(live)))
        else $error("a_r7_capture");
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(snap_q))
        else $error("a_r7_hold");

endmodule

// File: rtl/tmr_interval_top.sv
`timescale 1ns/1ps
module tmr_interval_top
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int HALF_W = CNT_W / 2;

    tmr_wstb_t        wstb;
    logic             ien, cont, start_pls, stop_pls, per_load;
    logic [CNT_W-1:0] period, per_next, count, snap;
    logic             running, timeout;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HALF_W];

    tmr_bus_decode #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .st_timeout (timeout),
        .st_running (running),
        .cf_ien     (ien),
        .cf_cont    (cont),
        .period     (period),
        .snap       (snap),
        .wstb       (wstb),
        .rdata      (bus_rdata)
    );

    tmr_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wstb.ctrl),
        .wr_per_lo (wstb.per_lo),
        .wr_per_hi (wstb.per_hi),
        .wdata     (bus_wdata[HALF_W-1:0]),
        .ien       (ien),
        .cont      (cont),
        .start_pls (start_pls),
        .stop_pls  (stop_pls),
        .period    (period),
        .per_next  (per_next),
        .per_load  (per_load)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pls (start_pls),
        .stop_pls  (stop_pls),
        .cont      (cont),
        .per_load  (per_load),
        .per_next  (per_next),
        .clr_to    (wstb.stat),
        .count     (count),
        .running   (running),
        .timeout   (timeout)
    );

    tmr_snap #(.CNT_W(CNT_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (wstb.snap),
        .live  (count),
        .snap  (snap)
    );

    assign irq = timeout && ien;

    // R9: no interrupt without the enable, none without a pending timeout
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && timeout))
        else $error("a_r9_needs_enable");

endmodule

// File: tb/sim_tmr_interval_top.sv
`timescale 1ns/1ps
module sim_tmr_interval_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    tmr_interval_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        logic [2:0]  addr;
        logic [31:0] exp;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    logic rd_act  = 1'b0;
    logic done    = 1'b0;

    // Scoreboard monitor: pops one expectation per read slot
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rd_act) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL scoreboard: read with no expectation, got %h", bus_rdata);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    n_tests++;
                    if (bus_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: addr %0d read %h expected %h", it.req, it.addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    // Each access occupies exactly one clock slot
    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string req);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.addr = a; it.exp = e; it.req = req;
        exp_q.push_back(it);
        rd_act = 1'b1;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; rd_act = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string req);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq %b expected %b", req, irq, e);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(1);

        // R1 / R2: reset values and full address map
        chk_irq(1'b0, "R1");
        bus_read(3'd0, 32'h0,    "R1");
        bus_read(3'd1, 32'h0,    "R1");
        bus_read(3'd2, 32'hFFFF, "R1");
        bus_read(3'd3, 32'hFFFF, "R1");
        bus_read(3'd4, 32'h0,    "R1");
        bus_read(3'd5, 32'h0,    "R1");
        bus_read(3'd6, 32'h0,    "R2");
        bus_read(3'd7, 32'h0,    "R2");

        // R6 / R2: period halves, upper data bits dropped
        bus_write(3'd2, 32'h1234_000A);
        bus_write(3'd3, 32'h0);
        bus_read(3'd2, 32'h000A, "R2");
        bus_read(3'd3, 32'h0,    "R6");
        bus_write(3'd4, 32'h0);
        bus_read(3'd4, 32'd10,   "R6");
        bus_read(3'd5, 32'h0,    "R7");
        idle(3);
        bus_write(3'd4, 32'h0);
        bus_read(3'd4, 32'd10,   "R5");

        // Continuous run, period 10, interrupt enabled (slot s)
        bus_write(3'd1, 32'h7);               // s
        bus_write(3'd4, 32'h0);               // s+1
        bus_read(3'd4, 32'd10,   "R7");       // s+2
        bus_read(3'd5, 32'h0,    "R7");       // s+3
        idle(2);
        bus_read(3'd4, 32'd10,   "R7");       // s+6 frozen
        bus_write(3'd4, 32'h0);               // s+7
        bus_read(3'd4, 32'd4,    "R3");       // s+8
        bus_read(3'd0, 32'h2,    "R3");       // s+9
        idle(2);
        bus_read(3'd0, 32'h3,    "R3");       // s+12
        chk_irq(1'b1, "R9");
        bus_write(3'd4, 32'h0);               // s+13
        bus_read(3'd4, 32'd9,    "R3");       // s+14 reload seen
        bus_write(3'd0, 32'h0);               // s+15
        chk_irq(1'b0, "R9");
        bus_read(3'd0, 32'h2,    "R8");       // s+16
        idle(5);
        bus_write(3'd0, 32'h0);               // s+22 clear meets expiry
        bus_read(3'd0, 32'h3,    "R8");       // s+23
        bus_write(3'd1, 32'h2);               // s+24 enable off
        chk_irq(1'b0, "R9");
        bus_read(3'd0, 32'h3,    "R9");       // s+25
        bus_write(3'd1, 32'hE);               // s+26 start+stop
        bus_read(3'd0, 32'h1,    "R5");       // s+27
        bus_write(3'd4, 32'h0);               // s+28
        bus_read(3'd4, 32'd6,    "R5");       // s+29
        idle(3);
        bus_write(3'd4, 32'h0);               // s+33
        bus_read(3'd4, 32'd6,    "R5");       // s+34 still frozen

        // One-shot, period 3
        bus_write(3'd0, 32'h0);               // s+35
        bus_write(3'd2, 32'h3);               // s+36
        bus_write(3'd1, 32'h5);               // s+37
        bus_read(3'd0, 32'h2,    "R4");       // s+38
        idle(3);
        bus_read(3'd0, 32'h1,    "R4");       // s+42
        chk_irq(1'b1, "R9");
        bus_write(3'd4, 32'h0);               // s+43
        bus_read(3'd4, 32'h0,    "R4");       // s+44
        idle(2);
        bus_read(3'd0, 32'h1,    "R4");       // s+47
        bus_write(3'd1, 32'h5);               // s+48 restart from zero
        bus_write(3'd4, 32'h0);               // s+49
        bus_read(3'd4, 32'd3,    "R5");       // s+50
        bus_write(3'd2, 32'h20);              // s+51 period write mid-run
        bus_write(3'd4, 32'h0);               // s+52
        bus_read(3'd4, 32'h20,   "R6");       // s+53
        bus_read(3'd0, 32'h3,    "R6");       // s+54 still running
        bus_read(3'd1, 32'h1,    "R5");       // strobes read as zero

        // Free-run over full range
        bus_write(3'd2, 32'hFFFF);            // a
        bus_write(3'd3, 32'hFFFF);            // a+1
        bus_write(3'd1, 32'h3);               // a+2
        bus_write(3'd4, 32'h0);               // a+3: ~snap = 1
        bus_read(3'd4, 32'hFFFE, "R10");
        bus_read(3'd5, 32'hFFFF, "R10");
        idle(10);
        bus_write(3'd5, 32'h0);               // a+16 via high address: ~snap = 1 + 13
        bus_read(3'd4, 32'hFFFF & ~(32'd1 + 32'd13), "R10");
        bus_read(3'd5, 32'hFFFF, "R7");
        bus_read(3'd1, 32'h3,    "R2");

        idle(2);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule